// File: doc/BRIEF.md
# Two-Level Nested Interrupt Controller

This block gathers interrupt requests for a small processor and issues one vectored request at a time. It has five sources. Two are external active-low pins, and each pin can sense either levels or falling edges. The other three are internal: two timer overflow flags and one serial flag, which is the OR of the transmit-done and receive-done bits. Each source has an enable bit and a priority bit. A global enable gates every source.

The controller keeps a two-bit service state. The codes are 00 when no handler runs, 01 while a low-priority handler runs, and 11 while a high-priority handler runs. A new request may interrupt a running handler only if its priority is strictly higher. When the processor acknowledges a request, the controller saves the state that was running, one entry deep. A return-from-interrupt strobe then restores that saved state.

The processor core, vector fetch, timers and serial logic are outside this block. The processor watches `req_o`/`req_idx_o`, pulses `ack_i` when it takes the vector, and pulses `reti_i` when the handler ends.

Top module: `nested_irq_ctrl`

## Requirements
- R1: Synchronous active-high reset clears both external flags, sets `lvl_o` to 00, sets the saved state to 00, and drives `req_o` and `req_idx_o` to 0. `lvl_o` only ever takes the codes 00, 01 or 11.
- R2: A falling edge on either external pin sets that pin's flag, in both sensing modes. The pin passes through a two-flop synchronizer and an edge register. As a result, `req_o` rises on the 4th rising clock edge after the pin falls, and not before.
- R3: In level mode (`ext_mode_i` bit = 0), the flag stays set while the pin is low and clears once the synchronized pin is high again. An acknowledge does not clear it.
- R4: In edge mode (`ext_mode_i` bit = 1), the flag stays set after the pin returns high. Only an acknowledge whose `req_idx_o` names that pin clears it. After that, only a new falling edge sets it again.
- R5: A source whose `en_mask_i` bit is 0 is never requested. While `glb_en_i` is 0, `req_o` is 0 one cycle later.
- R6: Source indices are: external pin 0 = 0, timer 0 = 1, external pin 1 = 2, timer 1 = 3, serial = 4. A source whose `prio_i` bit is 1 beats every low-priority source. Among sources of equal priority, the lowest index wins.
- R7: Timer overflow inputs are level requests at indices 1 (bit 0) and 3 (bit 1). The serial request at index 4 is `ser_tx_i` OR `ser_rx_i`.
- R8: On `ack_i`, the saved state takes the current state. `lvl_o` becomes 11 if the acknowledged source is high priority and 01 otherwise. `req_o` is 0 in the cycle that follows.
- R9: In state 00, any eligible source is requested. In state 01, only high-priority sources are requested. In state 11, nothing is requested.
- R10: On `reti_i` (without `ack_i`), `lvl_o` takes the saved state and the saved state becomes 00. `req_o` is 0 in the cycle that follows.
- R11: `req_o` and `req_idx_o` are registered: they reflect the source flags, masks and state one clock later. `req_idx_o` is 0 whenever `req_o` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ext_n_i | input | 2 | External active-low interrupt pins (bit 0 = pin 0) |
| ext_mode_i | input | 2 | Per-pin sensing mode: 0 level, 1 edge |
| tmr_ovf_i | input | 2 | Timer overflow flags (bit 0 = timer 0) |
| ser_tx_i | input | 1 | Serial transmit-done flag |
| ser_rx_i | input | 1 | Serial receive-done flag |
| glb_en_i | input | 1 | Global enable for all sources |
| en_mask_i | input | 5 | Per-source enable, indexed by source index |
| prio_i | input | 5 | Per-source priority (1 = high), indexed by source index |
| ack_i | input | 1 | Processor has taken the current vector |
| reti_i | input | 1 | Return-from-interrupt strobe |
| req_o | output | 1 | Registered interrupt request |
| req_idx_o | output | 3 | Source index of the request |
| lvl_o | output | 2 | Current service state (00, 01, 11) |

## Verification
The bench builds the block with its default synchronizer depth of two stages. This makes the pin-to-request latency exactly four clock edges, so a check one edge early can see that no request has appeared yet. A vector table covers arbitration, masking and the serial OR while the state is 00. Directed sequences then cover the following:
- level versus edge flag clearing around an acknowledge;
- a two-deep nest 00→01→11, unwound by two returns;
- a third return that finds the saved state cleared;
- a reset taken while a high-priority handler runs and an edge flag is pending.

// File: rtl/nirq_pkg.sv
package nirq_pkg;
  localparam int SRC_N  = 5;
  localparam int EXT_N  = 2;
  localparam int IDX_W  = $clog2(SRC_N);
  localparam int SRC_EXT0 = 0;
  localparam int SRC_TMR0 = 1;
  localparam int SRC_EXT1 = 2;
  localparam int SRC_TMR1 = 3;
  localparam int SRC_SER  = 4;
  localparam logic [1:0] LVL_IDLE = 2'b00;
  localparam logic [1:0] LVL_LOW  = 2'b01;
  localparam logic [1:0] LVL_HIGH = 2'b11;
endpackage

// File: rtl/nirq_ext_in.sv
module nirq_ext_in #(
  parameter int NPIN        = 2,
  parameter int SYNC_STAGES = 2
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [NPIN-1:0] pin_n,
  input  logic [NPIN-1:0] mode,
  input  logic [NPIN-1:0] clr,
  output logic [NPIN-1:0] pend_o
);
  for (genvar p = 0; p < NPIN; p++) begin : g_pin
    logic [SYNC_STAGES-1:0] sh;
    logic                   prev;
    logic                   flag;
    logic                   sync_n;
    logic                   fall;

    always_ff @(posedge clk) begin
      if (rst) sh <= '1;
      else     sh <= {sh[SYNC_STAGES-2:0], pin_n[p]};
    end
    assign sync_n = sh[SYNC_STAGES-1];

    always_ff @(posedge clk) begin
      if (rst) prev <= 1'b1;
      else     prev <= sync_n;
    end
    assign fall = prev & ~sync_n;

    // level mode tracks the pin, edge mode holds until cleared by acknowledge
    always_ff @(posedge clk) begin
      if (rst)          flag <= 1'b0;
      else if (fall)    flag <= 1'b1;
      else if (!mode[p]) flag <= flag & ~sync_n;
      else if (clr[p])  flag <= 1'b0;
    end
    assign pend_o[p] = flag;
  end
endmodule

// File: rtl/nirq_arb.sv
module nirq_arb
  import nirq_pkg::*;
#(
  parameter int N  = SRC_N,
  parameter int IW = IDX_W
) (
  input  logic [N-1:0]  elig,
  input  logic [N-1:0]  prio,
  input  logic [1:0]    lvl,
  output logic          valid,
  output logic [IW-1:0] idx
);
  logic          hi_hit, lo_hit;
  logic [IW-1:0] hi_idx, lo_idx;

  always_comb begin
    hi_hit = 1'b0; hi_idx = '0;
    lo_hit = 1'b0; lo_idx = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (elig[i] && prio[i]) begin
        hi_hit = 1'b1; hi_idx = IW'(i);
      end
      if (elig[i] && !prio[i]) begin
        lo_hit = 1'b1; lo_idx = IW'(i);
      end
    end
  end

  always_comb begin
    valid = 1'b0;
    idx   = '0;
    case (lvl)
      LVL_IDLE: begin
        if (hi_hit)      begin valid = 1'b1; idx = hi_idx; end
        else if (lo_hit) begin valid = 1'b1; idx = lo_idx; end
      end
      LVL_LOW: begin
        if (hi_hit) begin valid = 1'b1; idx = hi_idx; end
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/nirq_lvl.sv
module nirq_lvl
  import nirq_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       ack,
  input  logic       ack_high,
  input  logic       reti,
  output logic [1:0] lvl_o,
  output logic [1:0] saved_o
);
  always_ff @(posedge clk) begin
    if (rst) begin
      lvl_o   <= LVL_IDLE;
      saved_o <= LVL_IDLE;
    end else if (ack) begin
      saved_o <= lvl_o;
      lvl_o   <= ack_high ? LVL_HIGH : LVL_LOW;
    end else if (reti) begin
      lvl_o   <= saved_o;
      saved_o <= LVL_IDLE;
    end
  end
endmodule

// File: rtl/nested_irq_ctrl.sv
module nested_irq_ctrl
  import nirq_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [EXT_N-1:0] ext_n_i,
  input  logic [EXT_N-1:0] ext_mode_i,
  input  logic [1:0]       tmr_ovf_i,
  input  logic             ser_tx_i,
  input  logic             ser_rx_i,
  input  logic             glb_en_i,
  input  logic [SRC_N-1:0] en_mask_i,
  input  logic [SRC_N-1:0] prio_i,
  input  logic             ack_i,
  input  logic             reti_i,
  output logic             req_o,
  output logic [IDX_W-1:0] req_idx_o,
  output logic [1:0]       lvl_o
);
  logic [EXT_N-1:0] ext_pend;
  logic [EXT_N-1:0] ext_clr;
  logic [SRC_N-1:0] pend_all;
  logic [SRC_N-1:0] elig;
  logic             win_valid;
  logic [IDX_W-1:0] win_idx;
  logic [1:0]       saved_lvl;
  logic             ack_high;

  assign ext_clr[0] = ack_i && (req_idx_o == IDX_W'(SRC_EXT0));
  assign ext_clr[1] = ack_i && (req_idx_o == IDX_W'(SRC_EXT1));

  nirq_ext_in #(.NPIN(EXT_N), .SYNC_STAGES(SYNC_STAGES)) u_ext (
    .clk    (clk),
    .rst    (rst),
    .pin_n  (ext_n_i),
    .mode   (ext_mode_i),
    .clr    (ext_clr),
    .pend_o (ext_pend)
  );

  always_comb begin
    pend_all           = '0;
    pend_all[SRC_EXT0] = ext_pend[0];
    pend_all[SRC_TMR0] = tmr_ovf_i[0];
    pend_all[SRC_EXT1] = ext_pend[1];
    pend_all[SRC_TMR1] = tmr_ovf_i[1];
    pend_all[SRC_SER]  = ser_tx_i | ser_rx_i;
  end

  assign elig = pend_all & en_mask_i & {SRC_N{glb_en_i}};

  nirq_arb #(.N(SRC_N), .IW(IDX_W)) u_arb (
    .elig  (elig),
    .prio  (prio_i),
    .lvl   (lvl_o),
    .valid (win_valid),
    .idx   (win_idx)
  );

  assign ack_high = prio_i[req_idx_o];

  nirq_lvl u_lvl (
    .clk      (clk),
    .rst      (rst),
    .ack      (ack_i),
    .ack_high (ack_high),
    .reti     (reti_i),
    .lvl_o    (lvl_o),
    .saved_o  (saved_lvl)
  );

  always_ff @(posedge clk) begin
    if (rst || ack_i || reti_i) begin
      req_o     <= 1'b0;
      req_idx_o <= '0;
    end else begin
      req_o     <= win_valid;
      req_idx_o <= win_valid ? win_idx : '0;
    end
  end
endmodule

// File: rtl/nirq_chk.sv
module nirq_chk
  import nirq_pkg::*;
(
  input logic             clk,
  input logic             rst,
  input logic             ack_i,
  input logic             reti_i,
  input logic             glb_en_i,
  input logic [SRC_N-1:0] prio_i,
  input logic             req_o,
  input logic [IDX_W-1:0] req_idx_o,
  input logic [1:0]       lvl_o,
  input logic [1:0]       saved_lvl
);
  logic [SRC_N-1:0] prio_q;
  logic             ack_hi_q;
  always_ff @(posedge clk) begin
    prio_q   <= prio_i;
    ack_hi_q <= prio_i[req_idx_o];
  end

  // R1
  lvl_legal_chk: assert property (@(posedge clk) disable iff (rst)
    lvl_o != 2'b10);
  // R11
  idle_idx_zero_chk: assert property (@(posedge clk) disable iff (rst)
    !req_o |-> req_idx_o == '0);
  // R5
  glb_off_chk: assert property (@(posedge clk) disable iff (rst)
    !glb_en_i |=> !req_o);
  // R8
  ack_drop_chk: assert property (@(posedge clk) disable iff (rst)
    ack_i |=> !req_o);
  // R8
  ack_level_chk: assert property (@(posedge clk) disable iff (rst)
    ack_i |=> lvl_o == (ack_hi_q ? LVL_HIGH : LVL_LOW));
  // R9
  no_req_high_chk: assert property (@(posedge clk) disable iff (rst)
    lvl_o == LVL_HIGH |-> !req_o);
  // R9
  low_hi_only_chk: assert property (@(posedge clk) disable iff (rst)
    (req_o && lvl_o == LVL_LOW) |-> prio_q[req_idx_o]);
  // R10
  reti_restore_chk: assert property (@(posedge clk) disable iff (rst)
    (reti_i && !ack_i) |=> (lvl_o == $past(saved_lvl)) && (saved_lvl == LVL_IDLE) && !req_o);
endmodule

bind nested_irq_ctrl nirq_chk u_chk (
  .clk       (clk),
  .rst       (rst),
  .ack_i     (ack_i),
  .reti_i    (reti_i),
  .glb_en_i  (glb_en_i),
  .prio_i    (prio_i),
  .req_o     (req_o),
  .req_idx_o (req_idx_o),
  .lvl_o     (lvl_o),
  .saved_lvl (saved_lvl)
);

// File: tb/nested_irq_ctrl_tb.sv
module nested_irq_ctrl_tb;
  localparam int CLK_P = 10;
  localparam int NV = 9;
  // {glb, en[4:0], prio[4:0], tmr[1:0], tx, rx, exp_req, exp_idx[2:0]}
  localparam logic [18:0] VEC [NV] = '{
    {1'b1, 5'b11111, 5'b00000, 2'b01, 1'b0, 1'b0, 1'b1, 3'd1},
    {1'b1, 5'b11111, 5'b00000, 2'b11, 1'b0, 1'b0, 1'b1, 3'd1},
    {1'b1, 5'b11111, 5'b01000, 2'b11, 1'b0, 1'b0, 1'b1, 3'd3},
    {1'b1, 5'b11111, 5'b00000, 2'b00, 1'b0, 1'b1, 1'b1, 3'd4},
    {1'b1, 5'b11111, 5'b00000, 2'b00, 1'b1, 1'b0, 1'b1, 3'd4},
    {1'b1, 5'b11101, 5'b00000, 2'b11, 1'b0, 1'b0, 1'b1, 3'd3},
    {1'b0, 5'b11111, 5'b00000, 2'b11, 1'b1, 1'b1, 1'b0, 3'd0},
    {1'b1, 5'b00000, 5'b11111, 2'b11, 1'b1, 1'b1, 1'b0, 3'd0},
    {1'b1, 5'b11111, 5'b10000, 2'b11, 1'b1, 1'b0, 1'b1, 3'd4}
  };

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [1:0] ext_n = 2'b11, ext_mode = 2'b00, tmr = 2'b00;
  logic       tx = 1'b0, rx = 1'b0, glb = 1'b1, ack = 1'b0, reti = 1'b0;
  logic [4:0] en = 5'b11111, prio = 5'b00000;
  logic       req;
  logic [2:0] idx;
  logic [1:0] lvl;
  int total = 0, fails = 0;

  always #(CLK_P/2) clk = ~clk;

  nested_irq_ctrl u_dut (
    .clk(clk), .rst(rst), .ext_n_i(ext_n), .ext_mode_i(ext_mode),
    .tmr_ovf_i(tmr), .ser_tx_i(tx), .ser_rx_i(rx), .glb_en_i(glb),
    .en_mask_i(en), .prio_i(prio), .ack_i(ack), .reti_i(reti),
    .req_o(req), .req_idx_o(idx), .lvl_o(lvl)
  );

  task automatic chk(input string tag, input int act, input int exp);
    total++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: got %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic do_ack();
    @(negedge clk); ack = 1'b1;
    @(posedge clk); #1; ack = 1'b0;
  endtask

  task automatic do_reti();
    @(negedge clk); reti = 1'b1;
    @(posedge clk); #1; reti = 1'b0;
  endtask

  initial begin
    #(CLK_P * 100000);
    total++; fails++;
    $display("FAIL watchdog: got 0 expected 1 (run did not finish)");
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    // R1 reset state
    tick(3);
    chk("R1 req in reset", req, 0);
    chk("R1 idx in reset", idx, 0);
    chk("R1 lvl in reset", lvl, 0);
    @(negedge clk); rst = 1'b0;
    tick(2);
    chk("R1 req after reset", req, 0);

    // table walk: arbitration, masks, serial OR (R5 R6 R7)
    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      glb = VEC[i][18]; en = VEC[i][17:13]; prio = VEC[i][12:8];
      tmr = VEC[i][7:6]; tx = VEC[i][5]; rx = VEC[i][4];
      tick(2);
      chk($sformatf("R5/R6/R7 vec %0d req", i), req, VEC[i][3]);
      chk($sformatf("R5/R6/R7 vec %0d idx", i), idx, VEC[i][2:0]);
    end
    @(negedge clk);
    glb = 1'b1; en = 5'b11111; prio = 5'b00000; tmr = 2'b00; tx = 1'b0; rx = 1'b0;
    tick(2);

    // R2 R11 latency, R3 level mode
    @(negedge clk); ext_n[0] = 1'b0;
    tick(3);
    chk("R11 no req before 4th edge", req, 0);
    tick(1);
    chk("R2 req on 4th edge", req, 1);
    chk("R2 idx ext0", idx, 0);
    do_ack();
    chk("R8 lvl low after ack", lvl, 1);
    chk("R8 req drops after ack", req, 0);
    tick(2);
    chk("R9 low blocked in state 01", req, 0);
    do_reti();
    chk("R10 lvl restored to 00", lvl, 0);
    tick(2);
    chk("R3 level flag survives ack", req, 1);
    @(negedge clk); ext_n[0] = 1'b1;
    tick(5);
    chk("R3 level flag clears on rise", req, 0);

    // R4 edge mode on ext1
    ext_mode = 2'b10;
    @(negedge clk); ext_n[1] = 1'b0;
    tick(3);
    @(negedge clk); ext_n[1] = 1'b1;
    tick(6);
    chk("R4 edge flag held", req, 1);
    chk("R4 edge idx", idx, 2);
    do_ack();
    do_reti();
    tick(3);
    chk("R4 edge flag cleared by ack", req, 0);
    @(negedge clk); ext_n[1] = 1'b0;
    tick(5);
    chk("R4 rearm on new fall", req, 1);
    @(negedge clk); ext_n[1] = 1'b1;
    do_ack();
    do_reti();
    tick(3);
    chk("R4 cleared again", req, 0);
    ext_mode = 2'b00;

    // nesting R8 R9 R10 R6
    @(negedge clk); prio = 5'b01000; ext_n[0] = 1'b0;
    tick(5);
    chk("R6 ext0 alone", idx, 0);
    do_ack();
    chk("R8 lvl 01", lvl, 1);
    @(negedge clk); tmr[1] = 1'b1;
    tick(2);
    chk("R9 high accepted in 01", req, 1);
    chk("R9 high idx", idx, 3);
    do_ack();
    chk("R8 lvl 11", lvl, 3);
    @(negedge clk); tmr[0] = 1'b1;
    tick(3);
    chk("R9 nothing in 11", req, 0);
    @(negedge clk); tmr[1] = 1'b0;
    do_reti();
    chk("R10 back to 01", lvl, 1);
    tick(2);
    chk("R9 low still blocked", req, 0);
    do_reti();
    chk("R10 back to 00", lvl, 0);
    tick(2);
    chk("R6 equal prio order", idx, 0);
    do_reti();
    chk("R10 saved cleared to 00", lvl, 0);
    @(negedge clk); ext_n[0] = 1'b1; tmr[0] = 1'b0;
    tick(5);

    // R1 reset during high service with pending edge flag
    ext_mode = 2'b10;
    @(negedge clk); ext_n[1] = 1'b0; tmr[1] = 1'b1;
    tick(2);
    do_ack();
    chk("R8 lvl 11 before reset", lvl, 3);
    tick(3);
    @(negedge clk); ext_n[1] = 1'b1; tmr[1] = 1'b0;
    tick(3);
    @(negedge clk); rst = 1'b1;
    tick(1);
    chk("R1 lvl cleared by reset", lvl, 0);
    @(negedge clk); rst = 1'b0;
    tick(4);
    chk("R1 edge flag cleared by reset", req, 0);

    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule